// File: doc/BRIEF.md
# Sync-Character Discard Filter

This block sits in a serial receive path, after the character decoder and before the receive buffer. Each incoming character is 14 bits wide: one tag bit that marks it as a special character or a data character, and a 13-bit code. A 2-bit policy select chooses which filler characters are dropped. Those are the framing sync characters (two special codes, called JK and LM here) and one special idle code.

There are two modes. In buffer mode the block drives a write strobe for a downstream FIFO, and characters the policy drops are never written. In pass-through mode every character appears on the output. A per-character empty flag then tells external logic which characters the policy would have dropped.

The "keep the last sync of a run" rule needs one character of lookahead. For that reason every character is held in a one-character stage and leaves it only when the next character arrives.

Top module: `sync_discard_filter`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `fifo_wr` and `out_empty` are 0. The lookahead stage is emptied, so the first character accepted after reset produces no output.
- R2: A character accepted with `ch_vld` is presented on `out_ch` with `out_vld` high in the cycle after the next accepted character. Characters leave in arrival order. A cycle without `ch_vld` gives `out_vld` = 0 in the following cycle.
- R3: With policy 0 (and the reserved value 3, which acts as 0), every character is written in buffer mode, and `out_empty` stays 0 in pass-through mode.
- R4: With policy 1 in buffer mode, a sync character (JK or LM) that is followed by another sync character is not written. The last sync before a non-sync character is written.
- R5: With policy 2 in buffer mode, the rule of R4 applies, and in addition every idle character is not written.
- R6: In pass-through mode (`bypass_en` = 1), every character is presented with `out_vld` high, and `fifo_wr` stays 0.
- R7: With policy 1 in pass-through mode, `out_empty` is high exactly for the sync characters that are followed by another sync character.
- R8: With policy 2 in pass-through mode, `out_empty` is high for every sync character and every idle character.
- R9: Data characters and special characters other than JK, LM and idle are always written in buffer mode, and are never flagged empty in pass-through mode.
- R10: The policy and the mode are sampled together with each character. A change applies from the next character boundary onwards, and characters already accepted keep their settings.
- R11: `fifo_wr` and `out_empty` are never high together, and each of them implies `out_vld`.
- R12: Character encoding: bit 13 = 1 marks a special character, and bits 12:0 hold the code. JK = 13'h0A1, LM = 13'h0B2 and idle = 13'h0C5 by default. A data character (bit 13 = 0) that carries one of these codes is an ordinary data character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_vld | input | 1 | A decoded character is present on `ch_in` |
| ch_in | input | 14 | Decoded character: special tag in bit 13, code in bits 12:0 |
| pol_sel | input | 2 | Discard policy: 0 keep all, 1 last sync only, 2 also strip idle, 3 same as 0 |
| bypass_en | input | 1 | 1 = pass-through mode, 0 = buffer mode |
| out_vld | output | 1 | A character is presented on `out_ch` |
| out_ch | output | 14 | Character leaving the lookahead stage |
| fifo_wr | output | 1 | Write strobe for the downstream buffer (buffer mode only) |
| out_empty | output | 1 | Pass-through mode: the presented character is one the policy would drop |

## Verification
The main sweep sends every ordered triple drawn from six character kinds: a plain data character, JK, LM, idle, an unrelated special character, and a data character that carries the JK code. It does this under all four policy values in both modes. The sync-then-sync and sync-then-other pairs separate the lookahead rule from a plain match on the current character. The idle and the unrelated-special entries tell policy 1 apart from policy 2. The data character with a sync code checks that the special tag takes part in the match. A second stream changes policy and mode on every character, which shows whether the settings travel with the held character. Idle gaps between characters and a reset in mid-stream check that the stage neither loses nor invents a character.

// File: rtl/sdf_pkg.sv
// Shared types for the sync-character discard filter.
// Assumes a 2-bit policy select. The value 3 is reserved.
package sdf_pkg;

    typedef enum logic [1:0] {
        POL_KEEP_ALL   = 2'd0,
        POL_LAST_SYNC  = 2'd1,
        POL_STRIP_FILL = 2'd2,
        POL_RESERVED   = 2'd3
    } policy_e;

    // Settings and class flags that travel with a held character
    typedef struct packed {
        logic    byp;
        policy_e pol;
        logic    is_sync;
        logic    is_idle;
    } hold_tag_t;

endpackage

// File: rtl/sdf_classify.sv
// Character classifier: flags JK/LM sync characters and the idle character.
// Assumes the top bit of a character is the special tag and the rest is the code.
module sdf_classify #(
    parameter int                 CHAR_W    = 14,
    parameter logic [CHAR_W-2:0]  JK_CODE   = 13'h0A1,
    parameter logic [CHAR_W-2:0]  LM_CODE   = 13'h0B2,
    parameter logic [CHAR_W-2:0]  IDLE_CODE = 13'h0C5
) (
    input  logic [CHAR_W-1:0] ch,
    output logic              is_sync,
    output logic              is_idle
);
    localparam int CODE_W = CHAR_W - 1;

    logic              special;
    logic [CODE_W-1:0] code;

    // Split the tag from the code and compare only special characters
    always_comb begin
        special = ch[CHAR_W-1];
        code    = ch[CODE_W-1:0];
        is_sync = special && ((code == JK_CODE) || (code == LM_CODE));
        is_idle = special && (code == IDLE_CODE);
    end

endmodule

// File: rtl/sdf_hold_stage.sv
// One-character lookahead stage: keeps the last accepted character with its
// policy, mode and class flags until the next character arrives.
// Assumes load is asserted exactly on accepted characters.
module sdf_hold_stage #(
    parameter int CHAR_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [CHAR_W-1:0]        in_ch,
    input  sdf_pkg::hold_tag_t       in_tag,
    output logic                     hold_vld,
    output logic [CHAR_W-1:0]        hold_ch,
    output sdf_pkg::hold_tag_t       hold_tag
);

    // Capture a new character, or flush the stage on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_ch  <= '0;
            hold_tag <= '0;
        end else if (load) begin
            hold_vld <= 1'b1;
            hold_ch  <= in_ch;
            hold_tag <= in_tag;
        end
    end

endmodule

// File: rtl/sdf_verdict.sv
// Discard decision for the held character, given the class of the character
// that follows it. Assumes the reserved policy value behaves as keep-all.
module sdf_verdict (
    input  sdf_pkg::hold_tag_t held,
    input  logic               next_sync,
    output logic               drop_fifo,
    output logic               drop_flag
);
    import sdf_pkg::*;

    policy_e eff_pol;
    logic    run_inner;

    // Fold the reserved policy into keep-all
    always_comb begin
        eff_pol = (held.pol == POL_RESERVED) ? POL_KEEP_ALL : held.pol;
    end

    // A sync followed by another sync is not the last of its run
    always_comb begin
        run_inner = held.is_sync && next_sync;
    end

    // Per-policy verdicts for buffer mode and for pass-through flagging
    always_comb begin
        drop_fifo = 1'b0;
        drop_flag = 1'b0;
        case (eff_pol)
            POL_LAST_SYNC: begin
                drop_fifo = run_inner;
                drop_flag = run_inner;
            end
            POL_STRIP_FILL: begin
                drop_fifo = run_inner || held.is_idle;
                drop_flag = held.is_sync || held.is_idle;
            end
            default: begin
                drop_fifo = 1'b0;
                drop_flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sync_discard_filter.sv
// Sync-character discard filter, top level.
// Each accepted character waits in a one-character stage. When the next one
// arrives, the held character is presented with a buffer write strobe
// (buffer mode) or an empty flag (pass-through mode).
// Assumes a synchronous active-low reset and one character per ch_vld cycle.
module sync_discard_filter #(
    parameter int                 CHAR_W    = 14,
    parameter logic [CHAR_W-2:0]  JK_CODE   = 13'h0A1,
    parameter logic [CHAR_W-2:0]  LM_CODE   = 13'h0B2,
    parameter logic [CHAR_W-2:0]  IDLE_CODE = 13'h0C5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_vld,
    input  logic [CHAR_W-1:0] ch_in,
    input  logic [1:0]        pol_sel,
    input  logic              bypass_en,
    output logic              out_vld,
    output logic [CHAR_W-1:0] out_ch,
    output logic              fifo_wr,
    output logic              out_empty
);
    import sdf_pkg::*;

    logic              in_sync;
    logic              in_idle;
    hold_tag_t         in_tag;
    logic              hold_vld;
    logic [CHAR_W-1:0] hold_ch;
    hold_tag_t         hold_tag;
    logic              drop_fifo;
    logic              drop_flag;
    logic              emit;

    sdf_classify #(
        .CHAR_W   (CHAR_W),
        .JK_CODE  (JK_CODE),
        .LM_CODE  (LM_CODE),
        .IDLE_CODE(IDLE_CODE)
    ) u_classify (
        .ch     (ch_in),
        .is_sync(in_sync),
        .is_idle(in_idle)
    );

    // Bundle the settings that travel with the incoming character
    always_comb begin
        in_tag.byp     = bypass_en;
        in_tag.pol     = policy_e'(pol_sel);
        in_tag.is_sync = in_sync;
        in_tag.is_idle = in_idle;
    end

    sdf_hold_stage #(
        .CHAR_W(CHAR_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ch_vld),
        .in_ch   (ch_in),
        .in_tag  (in_tag),
        .hold_vld(hold_vld),
        .hold_ch (hold_ch),
        .hold_tag(hold_tag)
    );

    sdf_verdict u_verdict (
        .held     (hold_tag),
        .next_sync(in_sync),
        .drop_fifo(drop_fifo),
        .drop_flag(drop_flag)
    );

    // The held character leaves when a new one arrives
    always_comb begin
        emit = ch_vld && hold_vld;
    end

    // Output register: present the leaving character with its verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_ch    <= '0;
            fifo_wr   <= 1'b0;
            out_empty <= 1'b0;
        end else begin
            out_vld   <= emit;
            fifo_wr   <= emit && !hold_tag.byp && !drop_fifo;
            out_empty <= emit && hold_tag.byp && drop_flag;
            if (emit) begin
                out_ch <= hold_ch;
            end
        end
    end

endmodule

// File: rtl/sdf_chk.sv
// Property checker for the discard filter, attached to the top by bind.
// Assumes the same parameter values as the module it watches.
module sdf_chk #(
    parameter int                 CHAR_W    = 14,
    parameter logic [CHAR_W-2:0]  JK_CODE   = 13'h0A1,
    parameter logic [CHAR_W-2:0]  LM_CODE   = 13'h0B2,
    parameter logic [CHAR_W-2:0]  IDLE_CODE = 13'h0C5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ch_vld,
    input logic              out_vld,
    input logic [CHAR_W-1:0] out_ch,
    input logic              fifo_wr,
    input logic              out_empty
);
    localparam int CODE_W = CHAR_W - 1;

    logic              out_special;
    logic [CODE_W-1:0] out_code;

    // Decode the presented character for the filler check
    always_comb begin
        out_special = out_ch[CHAR_W-1];
        out_code    = out_ch[CODE_W-1:0];
    end

    // R11
    wr_excl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !out_empty);

    // R11
    wr_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> out_vld);

    // R11
    empty_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> out_vld);

    // R9
    empty_only_filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> (out_special && ((out_code == JK_CODE) ||
                       (out_code == LM_CODE) || (out_code == IDLE_CODE))));

    // R2
    vld_after_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(ch_vld));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_vld);

endmodule

bind sync_discard_filter sdf_chk #(
    .CHAR_W   (CHAR_W),
    .JK_CODE  (JK_CODE),
    .LM_CODE  (LM_CODE),
    .IDLE_CODE(IDLE_CODE)
) u_sdf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_vld   (ch_vld),
    .out_vld  (out_vld),
    .out_ch   (out_ch),
    .fifo_wr  (fifo_wr),
    .out_empty(out_empty)
);

// File: tb/sync_discard_filter_bench.sv
// Sweep bench for the sync-character discard filter.
module sync_discard_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 14;
    localparam logic [12:0] C_JK   = 13'h0A1;
    localparam logic [12:0] C_LM   = 13'h0B2;
    localparam logic [12:0] C_IDLE = 13'h0C5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch_vld = 1'b0;
    logic [CW-1:0] ch_in = '0;
    logic [1:0]    pol_sel = 2'd0;
    logic          bypass_en = 1'b0;
    logic          out_vld;
    logic [CW-1:0] out_ch;
    logic          fifo_wr;
    logic          out_empty;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // Model of the held character
    bit          p_vld = 0;
    logic [CW-1:0] p_ch = '0;
    int          p_pol = 0;
    bit          p_byp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_discard_filter u_sync_discard_filter (
        .clk(clk), .rst_n(rst_n), .ch_vld(ch_vld), .ch_in(ch_in),
        .pol_sel(pol_sel), .bypass_en(bypass_en), .out_vld(out_vld),
        .out_ch(out_ch), .fifo_wr(fifo_wr), .out_empty(out_empty)
    );

    // Character kinds used by the sweeps (R12 encoding)
    function automatic logic [CW-1:0] kind(int k);
        case (k)
            0: return {1'b0, 13'h0005};
            1: return {1'b1, C_JK};
            2: return {1'b1, C_LM};
            3: return {1'b1, C_IDLE};
            4: return {1'b1, 13'h00F7};
            default: return {1'b0, C_JK};
        endcase
    endfunction

    function automatic bit m_sync(logic [CW-1:0] c);
        return c[13] && (c[12:0] == C_JK || c[12:0] == C_LM);
    endfunction

    function automatic bit m_idle(logic [CW-1:0] c);
        return c[13] && (c[12:0] == C_IDLE);
    endfunction

    function automatic string tag_for(logic [CW-1:0] c, int pol, bit byp);
        int ep = (pol == 3) ? 0 : pol;
        if (!c[13] && c[12:0] == C_JK) return "R12";
        if (!m_sync(c) && !m_idle(c)) return "R9";
        if (byp) return (ep == 2) ? "R8" : (ep == 1) ? "R7" : "R6";
        return (ep == 2) ? "R5" : (ep == 1) ? "R4" : "R3";
    endfunction

    task automatic check_out(string req, bit ev, bit ew, bit ee, logic [CW-1:0] ech);
        checks++;
        if (out_vld !== ev || fifo_wr !== ew || out_empty !== ee ||
            (ev && out_ch !== ech)) begin
            errors++;
            $display("FAIL %s: vld/wr/empty/ch got %b%b%b %h expected %b%b%b %h",
                     req, out_vld, fifo_wr, out_empty, out_ch, ev, ew, ee, ech);
        end
        checks++;
        if (fifo_wr && out_empty) begin
            errors++;
            $display("FAIL R11: wr/empty got 11 expected not both");
        end
    endtask

    // Offer one character and check what leaves the stage
    task automatic send(logic [CW-1:0] c, int pol, bit byp, string force_tag);
        int  ep;
        bit  drop_f, drop_b, ew, ee;
        string t;
        ch_vld = 1'b1; ch_in = c; pol_sel = pol[1:0]; bypass_en = byp;
        ep = (p_pol == 3) ? 0 : p_pol;
        drop_f = (ep >= 1 && m_sync(p_ch) && m_sync(c)) || (ep == 2 && m_idle(p_ch));
        drop_b = (ep == 1 && m_sync(p_ch) && m_sync(c)) ||
                 (ep == 2 && (m_sync(p_ch) || m_idle(p_ch)));
        ew = p_vld && !p_byp && !drop_f;
        ee = p_vld && p_byp && drop_b;
        t = (force_tag != "") ? force_tag : p_vld ? tag_for(p_ch, p_pol, p_byp) : "R2";
        @(negedge clk);
        check_out(t, p_vld, ew, ee, p_ch);
        p_vld = 1; p_ch = c; p_pol = pol; p_byp = byp;
    endtask

    task automatic gap();
        ch_vld = 1'b0;
        @(negedge clk);
        check_out("R2", 0, 0, 0, '0);
    endtask

    task automatic do_reset();
        ch_vld = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R1", 0, 0, 0, '0);
        rst_n = 1'b1;
        p_vld = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        send(kind(1), 1, 0, "R1");
        // Exhaustive triples under every policy and mode
        for (int pol = 0; pol < 4; pol++) begin
            for (int byp = 0; byp < 2; byp++) begin
                for (int a = 0; a < 6; a++)
                    for (int b = 0; b < 6; b++)
                        for (int c = 0; c < 6; c++) begin
                            send(kind(a), pol, byp[0], "");
                            send(kind(b), pol, byp[0], "");
                            send(kind(c), pol, byp[0], "");
                        end
                gap();
            end
        end
        // Settings change on every character: R10
        for (int i = 0; i < 240; i++) begin
            send(kind((i * 7 + i / 5) % 6), i % 4, ((i / 3) % 2) == 1, "R10");
            if (i % 37 == 36) gap();
        end
        // Mid-stream reset flushes the held character
        do_reset();
        send(kind(2), 2, 1, "R1");
        send(kind(0), 2, 1, "");
        gap();
        send(kind(4), 0, 0, "");
        summary();
        done = 1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no end expected end of run");
            summary();
            $finish;
        end
    end

endmodule